// File: doc/BRIEF.md
# Programmable Up/Down Counter with Input-Driven Modes

This block is a counter whose clock and enable source can be changed through a 3-bit mode field. It can count on every internal clock cycle or follow step pulses from a built-in quadrature/step decoder. It can also jump back to its preset on an external edge, count only while an external level is high, or start counting when an external edge arrives. The count runs between zero and a preset limit, upward or downward. Each time it wraps, it gives a single-cycle event pulse.

Software reaches the block through a plain register port: address, write data, write strobe and combinational read data. The preset can be double-buffered, so that a new limit takes effect only at the next wrap. The two external pins are asynchronous and are resynchronised inside the block. The register port has no valid/ready handshake and is never back-pressured. A write strobe always completes in its own cycle.

Top module: `mode_counter`

## Requirements
- R1: Register map, with all other addresses reading zero. Address 0x00 is the control register: bit 0 enable, bit 4 direction (1 = down), bit 7 preset buffering. Address 0x04 holds the mode in bits 2:0. Address 0x24 is the count and address 0x2C is the preset. After reset the control, mode and count registers read 0, the preset reads all ones and evt_o is low.
- R2: In mode 0, with enable set and direction up, the count steps by one on every clock. When a step starts from a value at or above the active preset, the count becomes 0 instead and evt_o is high for exactly that one cycle.
- R3: Counting down, a step from 0 loads the preset and pulses evt_o. Any other step subtracts one.
- R4: With enable clear, the count does not change in any mode except mode 4.
- R5: With buffering on, a preset write changes the read-back value at once but the active limit only at the next wrap or reload. With buffering off, the limit changes immediately.
- R6: A write to the count register loads the written value on that edge. It overrides any step in the same cycle, and no event is produced.
- R7: Mode 1 steps on each rising edge of ext_in[1]. It counts down when ext_in[0] is high and up when it is low. The control direction bit is ignored.
- R8: Mode 2 steps on each rising edge of ext_in[0]. It counts down when ext_in[1] is high. The control direction bit is ignored.
- R9: Mode 3 steps once on every change of either pin (x4 quadrature). The sequence {ext_in[1],ext_in[0]} 00→01→11→10→00 counts up; the reverse sequence counts down.
- R10: Mode 4 counts like mode 0. In addition, a rising edge on ext_in[0] reloads the count with the preset value.
- R11: Mode 5 counts like mode 0, but only while ext_in[0] is high. The count holds, without being cleared, while ext_in[0] is low.
- R12: In mode 6, a rising edge on ext_in[0] sets the enable bit, which then reads back as 1. The count is not cleared and then runs like mode 0.
- R13: ext_in passes through two flops before use. A pin change made before edge k acts on the count at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address for both reads and writes |
| reg_wdata | input | W | Write data |
| reg_we | input | 1 | Write strobe; the write completes in the same cycle |
| reg_rdata | output | W | Combinational read data for reg_addr |
| ext_in | input | 2 | Asynchronous external pins (bit 0 = input 1, bit 1 = input 2) |
| evt_o | output | 1 | One-cycle pulse on each wrap |

## Verification
A register write becomes visible on the edge that takes the strobe. The count then moves one step per following edge, so after n more edges the expected value is computed arithmetically modulo preset+1. External pin changes act only on the second edge after they are applied, because of the two synchroniser flops and the edge register. In mode 6 the first step comes one edge after that, since the edge first sets enable. The bench drives every input just after a falling edge and moves forward only in whole cycles. It reads results at a falling edge once the exact number of edges has passed, and it counts events on every falling edge.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;
  typedef enum logic [2:0] {
    M_INT    = 3'd0,
    M_ENC_A  = 3'd1,
    M_ENC_B  = 3'd2,
    M_ENC_AB = 3'd3,
    M_RELOAD = 3'd4,
    M_GATE   = 3'd5,
    M_TRIG   = 3'd6
  } smode_e;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h24;
  localparam logic [7:0] A_ARR  = 8'h2C;

  localparam int B_EN  = 0;
  localparam int B_DIR = 4;
  localparam int B_PRE = 7;
endpackage

// File: rtl/mcnt_sync.sv
module mcnt_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/mcnt_decoder.sv
module mcnt_decoder
  import mcnt_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] lvl_i,
  input  logic [1:0] rise_i,
  input  logic [1:0] fall_i,
  output logic       step_o,
  output logic       down_o
);
  logic a_edge, b_edge;

  assign a_edge = rise_i[0] | fall_i[0];
  assign b_edge = rise_i[1] | fall_i[1];

  always_comb begin
    step_o = 1'b0;
    down_o = 1'b0;
    case (mode_i)
      M_ENC_A: begin
        step_o = rise_i[1];
        down_o = lvl_i[0];
      end
      M_ENC_B: begin
        step_o = rise_i[0];
        down_o = lvl_i[1];
      end
      M_ENC_AB: begin
        // a change on both pins at once carries no direction: dropped
        step_o = a_edge ^ b_edge;
        down_o = a_edge ? (lvl_i[0] == lvl_i[1]) : (lvl_i[0] != lvl_i[1]);
      end
      default: begin
        step_o = 1'b0;
        down_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mcnt_core.sv
module mcnt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         down_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         reload_i,
  input  logic         arr_wr_i,
  input  logic [W-1:0] arr_val_i,
  input  logic         preload_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] arr_shadow_o,
  output logic [W-1:0] arr_act_o,
  output logic         upd_o,
  output logic         evt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, shadow_q, act_q;
  logic         evt_q;
  logic         wrap;

  assign wrap  = tick_i && (down_i ? (cnt_q == '0) : (cnt_q >= act_q));
  assign upd_o = !load_i && (reload_i || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (reload_i) begin
        cnt_q <= shadow_q;
      end else if (tick_i) begin
        if (wrap) begin
          cnt_q <= down_i ? shadow_q : '0;
          evt_q <= 1'b1;
        end else begin
          cnt_q <= down_i ? cnt_q - ONE : cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      act_q    <= '1;
    end else begin
      if (upd_o) act_q <= shadow_q;
      if (arr_wr_i) begin
        shadow_q <= arr_val_i;
        if (!preload_i) act_q <= arr_val_i;
      end
    end
  end

  assign cnt_o        = cnt_q;
  assign arr_shadow_o = shadow_q;
  assign arr_act_o    = act_q;
  assign evt_o        = evt_q;
endmodule

// File: rtl/mode_counter.sv
module mode_counter
  import mcnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic         reg_we,
  output logic [W-1:0] reg_rdata,
  input  logic [1:0]   ext_in,
  output logic         evt_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] lvl, rise, fall;
  logic            ctl_en, ctl_dir, ctl_pre;
  logic [2:0]      mode_q;
  logic            dec_step, dec_down;
  logic            tick, down, reload, upd;
  logic            wr_ctrl, wr_mode, wr_cnt, wr_arr;
  logic [W-1:0]    cnt_q, arr_shadow, arr_act;

  mcnt_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_in),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  mcnt_decoder u_dec (
    .mode_i(mode_q), .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .step_o(dec_step), .down_o(dec_down)
  );

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_cnt  = reg_we && (reg_addr == A_CNT);
  assign wr_arr  = reg_we && (reg_addr == A_ARR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_dir <= 1'b0;
      ctl_pre <= 1'b0;
      mode_q  <= 3'd0;
    end else begin
      if (wr_ctrl) begin
        ctl_en  <= reg_wdata[B_EN];
        ctl_dir <= reg_wdata[B_DIR];
        ctl_pre <= reg_wdata[B_PRE];
      end else if (mode_q == M_TRIG && rise[0]) begin
        ctl_en <= 1'b1;
      end
      if (wr_mode) mode_q <= reg_wdata[2:0];
    end
  end

  always_comb begin
    case (mode_q)
      M_INT, M_RELOAD, M_TRIG: tick = ctl_en;
      M_GATE:                  tick = ctl_en && lvl[0];
      M_ENC_A, M_ENC_B, M_ENC_AB: tick = ctl_en && dec_step;
      default:                 tick = 1'b0;
    endcase
  end

  assign down   = (mode_q == M_ENC_A || mode_q == M_ENC_B || mode_q == M_ENC_AB)
                  ? dec_down : ctl_dir;
  assign reload = (mode_q == M_RELOAD) && rise[0];

  mcnt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .tick_i(tick), .down_i(down),
    .load_i(wr_cnt), .load_val_i(reg_wdata),
    .reload_i(reload),
    .arr_wr_i(wr_arr), .arr_val_i(reg_wdata), .preload_i(ctl_pre),
    .cnt_o(cnt_q), .arr_shadow_o(arr_shadow), .arr_act_o(arr_act),
    .upd_o(upd), .evt_o(evt_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_EN]  = ctl_en;
        reg_rdata[B_DIR] = ctl_dir;
        reg_rdata[B_PRE] = ctl_pre;
      end
      A_MODE:  reg_rdata[2:0] = mode_q;
      A_CNT:   reg_rdata = cnt_q;
      A_ARR:   reg_rdata = arr_shadow;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcnt_checker.sv
module mcnt_checker
  import mcnt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [7:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] arr_shadow,
  input logic [W-1:0] arr_act,
  input logic         en,
  input logic         pre,
  input logic         upd,
  input logic [2:0]   mode,
  input logic         gate_lvl,
  input logic         evt
);
  logic cnt_wr;
  assign cnt_wr = reg_we && (reg_addr == A_CNT);

  // R2 / R3: a wrap lands on zero or on the preset
  p_wrap_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (cnt == '0) || (cnt == $past(arr_shadow)));

  // R6: a software load wins and suppresses the event
  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(reg_wdata)) && !evt);

  // R4: disabled counter holds
  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr && mode != M_RELOAD) |=> $stable(cnt));

  // R11: gate low freezes the count
  p_gate_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_GATE && !gate_lvl && !cnt_wr) |=> $stable(cnt));

  // R5: buffered limit moves only on an update
  p_preload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && !upd) |=> $stable(arr_act));
endmodule

bind mode_counter mcnt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt(cnt_q), .arr_shadow(arr_shadow),
  .arr_act(arr_act), .en(ctl_en), .pre(ctl_pre), .upd(upd),
  .mode(mode_q), .gate_lvl(lvl[0]), .evt(evt_o)
);

// File: tb/mode_counter_test.sv
module mode_counter_test;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   reg_addr = 8'h00;
  logic [W-1:0] reg_wdata = '0;
  logic         reg_we = 1'b0;
  logic [W-1:0] reg_rdata;
  logic [1:0]   ext_in = 2'b00;
  logic         evt_o;

  int n_chk = 0;
  int n_fail = 0;
  int ev_seen = 0;

  mode_counter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ext_in(ext_in), .evt_o(evt_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (evt_o) ev_seen = ev_seen + 1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk = n_chk + 1;
    if (got != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    reg_addr  = a;
    reg_wdata = W'(d);
    reg_we    = 1'b1;
    cyc(1);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic pins(input logic [1:0] v);
    ext_in = v;
    cyc(4);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int v, ev0, k;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset values and map
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 mode", v, 0);
    rd(8'h24, v); chk("R1 cnt", v, 0);
    rd(8'h2C, v); chk("R1 arr", v, 65535);
    rd(8'h28, v); chk("R1 unmapped", v, 0);
    chk("R1 evt", int'(evt_o), 0);

    // R2 / R3 sweep over preset and direction
    for (int dir = 0; dir < 2; dir++) begin
      for (int a = 0; a < 6; a++) begin
        wr(8'h00, 0);
        wr(8'h04, 0);
        wr(8'h2C, a);
        wr(8'h24, dir ? a : 0);
        k = 13;
        wr(8'h00, 1 | (dir << 4));
        ev0 = ev_seen;
        cyc(k);
        rd(8'h24, v);
        if (dir == 0) chk("R2 up count", v, k % (a + 1));
        else          chk("R3 down count", v, a - (k % (a + 1)));
        chk(dir ? "R3 events" : "R2 events", ev_seen - ev0, k / (a + 1));
      end
    end

    // R4 disabled hold
    wr(8'h00, 0);
    wr(8'h2C, 1000);
    wr(8'h24, 7);
    cyc(5);
    rd(8'h24, v); chk("R4 hold", v, 7);

    // R6 write wins while running
    wr(8'h00, 1);
    cyc(3);
    wr(8'h24, 500);
    rd(8'h24, v); chk("R6 load", v, 500);
    cyc(3);
    rd(8'h24, v); chk("R6 after load", v, 503);

    // R5 buffered preset
    wr(8'h00, 0);
    wr(8'h2C, 9);
    wr(8'h00, 8'h80);
    wr(8'h2C, 3);
    rd(8'h2C, v); chk("R5 readback", v, 3);
    wr(8'h24, 7);
    wr(8'h00, 8'h81);
    ev0 = ev_seen;
    cyc(5);
    rd(8'h24, v); chk("R5 old limit", v, 2);
    chk("R5 first wrap", ev_seen - ev0, 1);
    cyc(2);
    rd(8'h24, v); chk("R5 new limit", v, 0);
    chk("R5 second wrap", ev_seen - ev0, 2);
    // R5 immediate preset
    wr(8'h00, 0);
    wr(8'h2C, 9);
    wr(8'h24, 7);
    wr(8'h2C, 3);
    wr(8'h00, 1);
    ev0 = ev_seen;
    cyc(1);
    rd(8'h24, v); chk("R5 immediate", v, 0);
    chk("R5 immediate evt", ev_seen - ev0, 1);

    // R7 mode 1, control dir set but ignored
    wr(8'h00, 0);
    pins(2'b00);
    wr(8'h2C, 1000);
    wr(8'h04, 1);
    wr(8'h24, 10);
    wr(8'h00, 8'h11);
    for (int i = 0; i < 3; i++) begin pins(2'b10); pins(2'b00); end
    rd(8'h24, v); chk("R7 up", v, 13);
    pins(2'b01);
    for (int i = 0; i < 5; i++) begin pins(2'b11); pins(2'b01); end
    rd(8'h24, v); chk("R7 down", v, 8);

    // R8 mode 2
    wr(8'h00, 0);
    pins(2'b00);
    wr(8'h04, 2);
    wr(8'h24, 10);
    wr(8'h00, 8'h11);
    for (int i = 0; i < 2; i++) begin pins(2'b01); pins(2'b00); end
    rd(8'h24, v); chk("R8 up", v, 12);
    pins(2'b10);
    for (int i = 0; i < 3; i++) begin pins(2'b11); pins(2'b10); end
    rd(8'h24, v); chk("R8 down", v, 9);

    // R9 mode 3 quadrature
    wr(8'h00, 0);
    pins(2'b00);
    wr(8'h04, 3);
    wr(8'h24, 100);
    wr(8'h00, 1);
    for (int i = 0; i < 2; i++) begin
      pins(2'b01); pins(2'b11); pins(2'b10); pins(2'b00);
    end
    rd(8'h24, v); chk("R9 forward", v, 108);
    pins(2'b10); pins(2'b11); pins(2'b01); pins(2'b00);
    rd(8'h24, v); chk("R9 reverse", v, 104);

    // R10 / R13 reload on edge
    wr(8'h00, 0);
    pins(2'b00);
    wr(8'h04, 4);
    wr(8'h2C, 50);
    wr(8'h24, 5);
    wr(8'h00, 1);
    cyc(2);
    ext_in = 2'b01;
    cyc(3);
    rd(8'h24, v); chk("R10 R13 reload", v, 50);
    ev0 = ev_seen;
    cyc(2);
    rd(8'h24, v); chk("R10 continue", v, 1);
    chk("R10 wrap evt", ev_seen - ev0, 1);
    pins(2'b00);

    // R11 gated
    wr(8'h00, 0);
    wr(8'h04, 5);
    wr(8'h2C, 1000);
    wr(8'h24, 0);
    wr(8'h00, 1);
    cyc(6);
    rd(8'h24, v); chk("R11 gate low", v, 0);
    ext_in = 2'b01;
    cyc(10);
    rd(8'h24, v); chk("R11 R13 gate high", v, 8);
    ext_in = 2'b00;
    cyc(10);
    rd(8'h24, v); chk("R11 hold after low", v, 10);

    // R12 trigger start
    wr(8'h00, 0);
    wr(8'h04, 6);
    wr(8'h24, 20);
    cyc(3);
    rd(8'h24, v); chk("R12 idle", v, 20);
    rd(8'h00, v); chk("R12 en before", v, 0);
    ext_in = 2'b01;
    cyc(6);
    rd(8'h24, v); chk("R12 started", v, 23);
    rd(8'h00, v); chk("R12 en set", v, 1);

    summary();
    $finish;
  end
endmodule